// File: doc/BRIEF.md
# Interrupt Mapping and Dispatch Unit

This block gathers 64 level-sensitive interrupt lines and forwards at most one of them at a time to the processor as a single outstanding request. Lines 0 to 31 belong to PCI slots and lines 32 to 63 to on-board devices. A register port exposes per-source mapping registers that carry an enable bit and a read-only target field, plus clear registers that software writes to retire the request it has serviced.

The request is presented on a plain valid flag and a 6-bit line number. It has no handshake and applies no back-pressure. Once raised, the request keeps the same number until software retires it, either through a clear write or by disabling the mapping register that gates it. In the same clock edge as a retirement, the selector runs again over the lines that are asserted and enabled. Eight PCI mapping registers each gate four consecutive lines. Each on-board line has a mapping register of its own.

Top module: `irq_dispatch_unit`

## Requirements
- R1: Reset leaves req_valid low and every mapping enable bit (bit 31) at 0. PCI mapping register s then reads 0x7C0 | (s<<2), and on-board mapping register k reads 0x7E0 + k.
- R2: PCI mapping register s reads at 0x0C04 + 8*s, and on-board mapping register k at 0x1004 + 8*k. The read value is {enable, 31-bit constant}. Any read with address bit 2 clear returns 0.
- R3: A mapping write changes only bit 31. Bits 30:0 keep their constant value whatever the write data holds.
- R4: PCI line i is gated by the enable of PCI mapping register i/4. On-board line 32+k is gated by the enable of on-board mapping register k. A line whose enable is 0 is never requested.
- R5: With no request outstanding, the lowest-numbered line that is asserted and enabled is requested. This puts every PCI line ahead of every on-board line. req_valid and req_num change on the clock edge that samples the triggering input or write.
- R6: While a request is outstanding, req_num holds, and newly asserted lines, including lower-numbered ones, are not selected. Dropping the requested line's level does not retire the request.
- R7: A write to 0x1404 + 32*s retires the outstanding request only if its number divided by 4 equals s. Address bits 7:5 give s, and on-board requests never match.
- R8: A write to 0x1804 + 8*k retires the outstanding request only if its number equals 32 + k.
- R9: A mapping write with bit 31 at 0 retires the outstanding request when that register gates the requested line. A disable write to any other register leaves the request in place.
- R10: Writes with address bit 2 clear, and writes outside the four register windows, change neither the enables nor the request. Reads of the clear windows return 0.
- R11: A retirement and the next selection happen on the same edge. If another line is asserted and enabled, req_valid stays high and req_num moves straight to that line, using the enables as updated by the retiring write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lvl | input | 64 | Interrupt line levels; bits 0-31 PCI, bits 32-63 on-board |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 16 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from cfg_addr |
| req_valid | output | 1 | A request is outstanding |
| req_num | output | 6 | Number of the outstanding line |

## Verification
Retirement and reselection share one clock edge, so they are the two functions that can fall in the same cycle. The bench provokes this case by asserting several enabled lines at once. It then drops the level of the current request and writes its clear register, or disables its mapping register, and repeats until every line has been walked. Each retiring write is judged on the next cycle: req_valid must stay high, req_num must equal the next-lowest asserted and enabled line computed in the bench, and req_valid must fall only when no candidate remains.

// File: rtl/irq_disp_pkg.sv
package irq_disp_pkg;

  typedef enum logic [2:0] {
    RGN_NONE    = 3'd0,
    RGN_PCI_MAP = 3'd1,
    RGN_BRD_MAP = 3'd2,
    RGN_PCI_CLR = 3'd3,
    RGN_BRD_CLR = 3'd4
  } region_e;

  localparam int unsigned TGT_FIELD_INIT = 32'h0000_07C0;
  localparam int unsigned BRD_TGT_OFS    = 32'h0000_0020;

  function automatic int unsigned pci_map_init(input int unsigned r);
    return TGT_FIELD_INIT | (r << 2);
  endfunction

  function automatic int unsigned brd_map_init(input int unsigned k);
    return (TGT_FIELD_INIT | BRD_TGT_OFS) + k;
  endfunction

endpackage

// File: rtl/irq_cfg_decode.sv
module irq_cfg_decode
  import irq_disp_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned IDX_W        = 5,
  parameter int unsigned N_PCI_REGS   = 8,
  parameter int unsigned N_BRD_REGS   = 32,
  parameter logic [15:0] PCI_MAP_BASE = 16'h0C00,
  parameter logic [15:0] BRD_MAP_BASE = 16'h1000,
  parameter logic [15:0] PCI_CLR_BASE = 16'h1400,
  parameter logic [15:0] BRD_CLR_BASE = 16'h1800
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           rgn,
  output logic              hi_word,
  output logic [IDX_W-1:0]  idx
);

  localparam int unsigned NWIN = 4;
  localparam logic [ADDR_W-1:0] WIN_BASE [NWIN] = '{
    ADDR_W'(PCI_MAP_BASE), ADDR_W'(BRD_MAP_BASE),
    ADDR_W'(PCI_CLR_BASE), ADDR_W'(BRD_CLR_BASE)
  };
  localparam int unsigned WIN_SPAN [NWIN] = '{
    N_PCI_REGS * 8, N_BRD_REGS * 8, N_PCI_REGS * 32, N_BRD_REGS * 8
  };
  localparam int unsigned WIN_SHIFT [NWIN] = '{3, 3, 5, 3};

  logic [NWIN-1:0] hit;
  logic [IDX_W-1:0] widx [NWIN];

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    logic [ADDR_W-1:0] off;
    assign off     = addr - WIN_BASE[w];
    assign hit[w]  = (addr >= WIN_BASE[w]) && (off < ADDR_W'(WIN_SPAN[w]));
    assign widx[w] = IDX_W'(off >> WIN_SHIFT[w]);
  end

  always_comb begin
    rgn = RGN_NONE;
    idx = '0;
    for (int w = 0; w < NWIN; w++) begin
      if (hit[w]) begin
        rgn = region_e'(3'(w + 1));
        idx = widx[w];
      end
    end
  end

  assign hi_word = addr[2];

endmodule

// File: rtl/irq_map_regs.sv
module irq_map_regs
  import irq_disp_pkg::*;
#(
  parameter int unsigned N_PCI_REGS    = 8,
  parameter int unsigned N_BRD_REGS    = 32,
  parameter int unsigned LINES_PER_REG = 4,
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned IDX_W         = 5,
  localparam int unsigned N_PCI_LINES  = N_PCI_REGS * LINES_PER_REG,
  localparam int unsigned NUM_LINES    = N_PCI_LINES + N_BRD_REGS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pci_wr,
  input  logic                 brd_wr,
  input  logic [IDX_W-1:0]     idx,
  input  logic                 en_bit,
  input  logic                 rd_pci,
  input  logic                 rd_brd,
  output logic [NUM_LINES-1:0] en_line_nxt,
  output logic [DATA_W-1:0]    rdata
);

  localparam int unsigned LOW_W = DATA_W - 1;

  logic [N_PCI_REGS-1:0] pci_en_q, pci_en_nxt;
  logic [N_BRD_REGS-1:0] brd_en_q, brd_en_nxt;
  logic [LOW_W-1:0] pci_low [N_PCI_REGS];
  logic [LOW_W-1:0] brd_low [N_BRD_REGS];

  for (genvar r = 0; r < N_PCI_REGS; r++) begin : g_pci
    assign pci_low[r]    = LOW_W'(pci_map_init(r));
    assign pci_en_nxt[r] = (pci_wr && idx == IDX_W'(r)) ? en_bit : pci_en_q[r];
    always_ff @(posedge clk) begin
      if (!rst_n) pci_en_q[r] <= 1'b0;
      else        pci_en_q[r] <= pci_en_nxt[r];
    end
  end

  for (genvar k = 0; k < N_BRD_REGS; k++) begin : g_brd
    assign brd_low[k]    = LOW_W'(brd_map_init(k));
    assign brd_en_nxt[k] = (brd_wr && idx == IDX_W'(k)) ? en_bit : brd_en_q[k];
    always_ff @(posedge clk) begin
      if (!rst_n) brd_en_q[k] <= 1'b0;
      else        brd_en_q[k] <= brd_en_nxt[k];
    end
  end

  for (genvar l = 0; l < N_PCI_LINES; l++) begin : g_pline
    assign en_line_nxt[l] = pci_en_nxt[l / LINES_PER_REG];
  end
  for (genvar k = 0; k < N_BRD_REGS; k++) begin : g_bline
    assign en_line_nxt[N_PCI_LINES + k] = brd_en_nxt[k];
  end

  always_comb begin
    rdata = '0;
    for (int r = 0; r < N_PCI_REGS; r++)
      if (rd_pci && idx == IDX_W'(r)) rdata = {pci_en_q[r], pci_low[r]};
    for (int k = 0; k < N_BRD_REGS; k++)
      if (rd_brd && idx == IDX_W'(k)) rdata = {brd_en_q[k], brd_low[k]};
  end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N     = 64,
  localparam int unsigned IW   = $clog2(N)
) (
  input  logic [N-1:0]  cand,
  output logic          found,
  output logic [IW-1:0] num
);

  always_comb begin
    found = 1'b0;
    num   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        num   = IW'(i);
      end
    end
  end

endmodule

// File: rtl/irq_req_track.sv
module irq_req_track #(
  parameter int unsigned N_PCI_LINES   = 32,
  parameter int unsigned LINES_PER_REG = 4,
  parameter int unsigned NUM_W         = 6,
  parameter int unsigned IDX_W         = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pci_hit,
  input  logic             brd_hit,
  input  logic [IDX_W-1:0] idx,
  input  logic             pick_found,
  input  logic [NUM_W-1:0] pick_num,
  output logic             req_valid,
  output logic [NUM_W-1:0] req_num
);

  logic             is_pci;
  logic [NUM_W-1:0] slot, brd_k, idx_w;
  logic             retire, reselect;

  assign is_pci   = req_num < NUM_W'(N_PCI_LINES);
  assign slot     = req_num / NUM_W'(LINES_PER_REG);
  assign brd_k    = req_num - NUM_W'(N_PCI_LINES);
  assign idx_w    = NUM_W'(idx);
  assign retire   = req_valid && ((pci_hit && is_pci && slot == idx_w) ||
                                  (brd_hit && !is_pci && brd_k == idx_w));
  assign reselect = !req_valid || retire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_num   <= '0;
    end else if (reselect) begin
      req_valid <= pick_found;
      req_num   <= pick_num;
    end
  end

endmodule

// File: rtl/irq_dispatch_unit.sv
module irq_dispatch_unit
  import irq_disp_pkg::*;
#(
  parameter int unsigned N_PCI_REGS    = 8,
  parameter int unsigned N_BRD_REGS    = 32,
  parameter int unsigned LINES_PER_REG = 4,
  parameter int unsigned ADDR_W        = 16,
  parameter int unsigned DATA_W        = 32,
  localparam int unsigned N_PCI_LINES  = N_PCI_REGS * LINES_PER_REG,
  localparam int unsigned NUM_LINES    = N_PCI_LINES + N_BRD_REGS,
  localparam int unsigned NUM_W        = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_lvl,
  input  logic                 cfg_wr_en,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [DATA_W-1:0]    cfg_wdata,
  output logic [DATA_W-1:0]    cfg_rdata,
  output logic                 req_valid,
  output logic [NUM_W-1:0]     req_num
);

  localparam int unsigned MAXR  = (N_PCI_REGS > N_BRD_REGS) ? N_PCI_REGS : N_BRD_REGS;
  localparam int unsigned IDX_W = (MAXR > 1) ? $clog2(MAXR) : 1;

  region_e          rgn;
  logic             hi_word;
  logic [IDX_W-1:0] idx;
  logic             wr_hi, en_bit;
  logic             pci_map_wr, brd_map_wr, pci_hit, brd_hit;
  logic [NUM_LINES-1:0] en_line_nxt, cand;
  logic             pick_found;
  logic [NUM_W-1:0] pick_num;
  logic             unused_wdata;

  irq_cfg_decode #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W),
    .N_PCI_REGS(N_PCI_REGS), .N_BRD_REGS(N_BRD_REGS)
  ) u_dec (
    .addr(cfg_addr), .rgn(rgn), .hi_word(hi_word), .idx(idx)
  );

  assign wr_hi        = cfg_wr_en && hi_word;
  assign en_bit       = cfg_wdata[DATA_W-1];
  assign unused_wdata = ^cfg_wdata[DATA_W-2:0];
  assign pci_map_wr   = wr_hi && (rgn == RGN_PCI_MAP);
  assign brd_map_wr   = wr_hi && (rgn == RGN_BRD_MAP);
  assign pci_hit      = (pci_map_wr && !en_bit) || (wr_hi && rgn == RGN_PCI_CLR);
  assign brd_hit      = (brd_map_wr && !en_bit) || (wr_hi && rgn == RGN_BRD_CLR);

  irq_map_regs #(
    .N_PCI_REGS(N_PCI_REGS), .N_BRD_REGS(N_BRD_REGS),
    .LINES_PER_REG(LINES_PER_REG), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_map (
    .clk(clk), .rst_n(rst_n),
    .pci_wr(pci_map_wr), .brd_wr(brd_map_wr), .idx(idx), .en_bit(en_bit),
    .rd_pci(hi_word && rgn == RGN_PCI_MAP),
    .rd_brd(hi_word && rgn == RGN_BRD_MAP),
    .en_line_nxt(en_line_nxt), .rdata(cfg_rdata)
  );

  assign cand = irq_lvl & en_line_nxt;

  irq_prio_pick #(.N(NUM_LINES)) u_pick (
    .cand(cand), .found(pick_found), .num(pick_num)
  );

  irq_req_track #(
    .N_PCI_LINES(N_PCI_LINES), .LINES_PER_REG(LINES_PER_REG),
    .NUM_W(NUM_W), .IDX_W(IDX_W)
  ) u_trk (
    .clk(clk), .rst_n(rst_n), .pci_hit(pci_hit), .brd_hit(brd_hit), .idx(idx),
    .pick_found(pick_found), .pick_num(pick_num),
    .req_valid(req_valid), .req_num(req_num)
  );

endmodule

// File: rtl/irq_dispatch_unit_chk.sv
module irq_dispatch_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [63:0] irq_lvl,
  input logic        cfg_wr_en,
  input logic [15:0] cfg_addr,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata,
  input logic        req_valid,
  input logic [5:0]  req_num
);

  logic [63:0] lvl_d;
  always_ff @(posedge clk) lvl_d <= irq_lvl;

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !cfg_wr_en |=> req_valid && $stable(req_num));

  // R5
  rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> lvl_d[req_num]);

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lvl == 64'd0) && !req_valid |=> !req_valid);

  // R2
  lo_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_addr[2] |-> cfg_rdata == 32'd0);

  // R9
  brd_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en && cfg_addr[15:7] == 9'h020 && cfg_addr[2] && !cfg_wdata[31] &&
    req_valid && req_num == {1'b1, cfg_addr[7:3]}
    |=> !(req_valid && req_num == $past(req_num)));

  // R8
  brd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en && cfg_addr[15:8] == 8'h18 && cfg_addr[2] &&
    req_valid && req_num == {1'b1, cfg_addr[7:3]} && !irq_lvl[req_num]
    |=> !(req_valid && req_num == $past(req_num)));

endmodule

bind irq_dispatch_unit irq_dispatch_unit_chk u_chk (.*);

// File: tb/irq_dispatch_unit_bench.sv
`timescale 1ns/1ps
module irq_dispatch_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_lvl = '0;
  logic        cfg_wr_en = 1'b0;
  logic [15:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid;
  logic [5:0]  req_num;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_dispatch_unit u_irq_dispatch_unit (
    .clk(clk), .rst_n(rst_n), .irq_lvl(irq_lvl), .cfg_wr_en(cfg_wr_en),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_num(req_num)
  );

  localparam logic [31:0] EN = 32'h8000_0000;

  function automatic logic [15:0] pci_map(int r); return 16'h0C04 + 16'(8 * r);  endfunction
  function automatic logic [15:0] brd_map(int k); return 16'h1004 + 16'(8 * k);  endfunction
  function automatic logic [15:0] pci_clr(int s); return 16'h1404 + 16'(32 * s); endfunction
  function automatic logic [15:0] brd_clr(int k); return 16'h1804 + 16'(8 * k);  endfunction
  function automatic logic [15:0] map_of(int l);
    return (l < 32) ? pci_map(l / 4) : brd_map(l - 32);
  endfunction
  function automatic logic [15:0] clr_of(int l);
    return (l < 32) ? pci_clr(l / 4) : brd_clr(l - 32);
  endfunction
  function automatic logic [31:0] ex(int l);
    return (l < 0) ? 32'd0 : (32'h40 | 32'(l));
  endfunction
  function automatic logic [31:0] rq();
    return req_valid ? {25'd0, 1'b1, req_num} : 32'd0;
  endfunction
  function automatic int lowest(logic [63:0] p);
    for (int i = 63; i >= 0; i--) if (p[i]) lowest = i;
    if (p == 64'd0) lowest = -1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_addr = '0; cfg_wdata = '0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] v);
    @(negedge clk);
    cfg_addr = a;
    #1 v = cfg_rdata;
    cfg_addr = '0;
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
    end
  end

  initial begin
    logic [31:0] v;
    logic [63:0] p;
    logic [63:0] pats [5];
    pats[0] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[1] = 64'h8000_0001_0000_0000;
    pats[2] = 64'hF0F0_0000_0000_0100;
    pats[3] = 64'h8000_0000_8000_0001;
    pats[4] = 64'h9249_2492_4924_9249;

    repeat (3) step();
    chk("R1 valid in reset", rq(), 32'd0);
    rst_n = 1'b1;
    step();
    chk("R1 valid after reset", rq(), 32'd0);
    for (int r = 0; r < 8; r++) begin
      rd(pci_map(r), v); chk("R1 pci map init", v, 32'h7C0 | 32'(r << 2));
      rd(pci_map(r) - 16'd4, v); chk("R2 pci low word", v, 32'd0);
    end
    for (int k = 0; k < 32; k++) begin
      rd(brd_map(k), v); chk("R1 brd map init", v, 32'h7E0 + 32'(k));
    end

    wr(pci_map(3), 32'hFFFF_FFFF);
    rd(pci_map(3), v); chk("R3 pci write keeps low", v, 32'h8000_07CC);
    wr(pci_map(3), 32'h0);
    rd(pci_map(3), v); chk("R3 pci disable", v, 32'h0000_07CC);
    wr(brd_map(5), 32'h7FFF_FFFF);
    rd(brd_map(5), v); chk("R3 brd write keeps low", v, 32'h0000_07E5);

    for (int l = 0; l < 64; l++) begin
      @(negedge clk); irq_lvl = 64'd1 << l;
      step(); chk("R4 disabled line ignored", rq(), 32'd0);
      wr(map_of(l), EN); chk("R5 single line", rq(), ex(l));
      @(negedge clk); irq_lvl = '0;
      step(); chk("R6 level drop keeps request", rq(), ex(l));
      if (l < 32) begin
        wr(pci_clr(((l / 4) + 1) % 8), 32'h0); chk("R7 wrong slot clear", rq(), ex(l));
      end else begin
        wr(brd_clr(((l - 32) + 1) % 32), 32'h0); chk("R8 wrong index clear", rq(), ex(l));
        wr(pci_clr((l - 32) % 8), 32'h0); chk("R7 pci clear on board request", rq(), ex(l));
      end
      wr(clr_of(l), 32'h0); chk("R7 R8 matching clear", rq(), 32'd0);
      wr(map_of(l), 32'h0);
    end

    for (int r = 0; r < 8; r++)  wr(pci_map(r), EN);
    for (int k = 0; k < 32; k++) wr(brd_map(k), EN);

    for (int t = 0; t < 5; t++) begin
      p = pats[t];
      @(negedge clk); irq_lvl = p;
      step();
      while (p != 64'd0) begin
        int c;
        c = lowest(p);
        chk("R5 priority", rq(), ex(c));
        p[c] = 1'b0;
        @(negedge clk); irq_lvl = p;
        wr(clr_of(c), 32'h0);
        chk("R11 retire and reselect", rq(), ex(lowest(p)));
      end
    end

    @(negedge clk); irq_lvl = 64'd1 << 40;
    step(); chk("R5 board line", rq(), ex(40));
    @(negedge clk); irq_lvl = (64'd1 << 40) | 64'd1;
    step(); chk("R6 lower line waits", rq(), ex(40));
    @(negedge clk); irq_lvl = 64'd1;
    wr(brd_clr(8), 32'h0); chk("R11 waiting line taken", rq(), ex(0));
    @(negedge clk); irq_lvl = '0;
    wr(pci_clr(0), 32'h0); chk("R7 clear slot 0", rq(), 32'd0);

    @(negedge clk); irq_lvl = (64'd1 << 40) | (64'd1 << 45);
    step(); chk("R5 two board lines", rq(), ex(40));
    wr(brd_map(8), 32'h0); chk("R9 board disable retires", rq(), ex(45));
    rd(brd_map(8), v); chk("R9 board enable cleared", v, 32'h7E8);
    @(negedge clk); irq_lvl = '0;
    wr(brd_clr(13), 32'h0); chk("R8 clear 45", rq(), 32'd0);

    @(negedge clk); irq_lvl = (64'd1 << 9) | (64'd1 << 10) | (64'd1 << 20);
    step(); chk("R5 pci lines", rq(), ex(9));
    wr(pci_map(0), 32'h0); chk("R9 other disable no retire", rq(), ex(9));
    wr(pci_map(2), 32'h0); chk("R9 pci disable retires", rq(), ex(20));

    wr(16'h14A0, 32'h0); chk("R10 low word clear ignored", rq(), ex(20));
    wr(16'h0C28, 32'h0); chk("R10 low word map write ignored", rq(), ex(20));
    rd(pci_map(5), v); chk("R10 enable unchanged", v, 32'h8000_07D4);
    wr(16'h2000, 32'hFFFF_FFFF); chk("R10 outside window", rq(), ex(20));
    rd(16'h14A4, v); chk("R10 clear window reads 0", v, 32'd0);
    rd(16'h1804, v); chk("R10 board clear reads 0", v, 32'd0);
    @(negedge clk); irq_lvl = '0;
    wr(pci_clr(5), 32'h0); chk("R7 final clear", rq(), 32'd0);

    done = 1;
    report();
  end

endmodule